// File: doc/BRIEF.md
# Serial Sync-Word Aligner and Deserializer

The block accepts one bit per serial clock cycle, qualified by a valid strobe, from a descrambled video link. It watches the last thirty accepted bits for the timing reference preamble: ten ones followed by twenty zeros, in arrival order. These are the ten-bit words 3FF, 000 and 000. When the preamble appears, the block restarts its divide-by-ten phase counter so that word boundaries follow the end of the preamble. It reports the event with a one-cycle pulse and flips a monitor flag.

Between preambles, every ten accepted bits form one parallel word. The word is assembled least-significant bit first. It is held on `word_out` until the next word completes. A one-cycle strobe is issued halfway through the hold time, so its active edge falls at the centre of the data valid window. Watched on a scope, the monitor flag has an even mark-space ratio when one preamble arrives per line. It shows an irregular period when bit errors damage or forge preambles.

A two-state machine records alignment. In `ST_HUNT`, words come out at the phase left by reset. The transition `HUNT->LOCK` happens on the first preamble match. `ST_LOCK` has only the self transition `LOCK->LOCK`: later matches realign the phase without leaving the state. The `aligned` output is high exactly in `ST_LOCK`.

Top module: `trs_word_aligner`

## Requirements
- R1: While `rst_n` is low, `word_out` is 0, and `word_stb`, `sync_pulse`, `syn_flag` and `aligned` are all 0.
- R2: A bit is accepted on a rising clock edge where `bit_vld` is 1. When the accepted bit completes ten ones followed by twenty zeros in arrival order, `sync_pulse` is 1 for exactly the following clock cycle.
- R3: Each completed word holds the last ten accepted bits, with the earliest of them in bit 0. `word_out` changes only on the edge that accepts the bit completing a word.
- R4: A preamble match completes a word, so `word_out` shows 000 in the same cycle as `sync_pulse`. The next accepted bit becomes bit 0 of a new word, whatever the previous phase was.
- R5: A match that coincides with the tenth bit of the current word leaves the word phase unchanged.
- R6: `word_stb` is a one-cycle pulse following the edge that accepts the fifth bit after a word update. It is never high at the same time as `sync_pulse`.
- R7: `syn_flag` inverts on every match and holds otherwise.
- R8: `aligned` (state `ST_LOCK`) stays 0 until the first match and then stays 1 until reset.
- R9: Before any match, the first word completes on the tenth accepted bit after reset.
- R10: Cycles with `bit_vld` low change neither `word_out` nor the bit phase, and they raise no strobe or pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Descrambled serial data bit |
| bit_vld | input | 1 | Bit qualifier; the bit is accepted when 1 |
| word_out | output | 10 | Assembled parallel word, bit 0 received first |
| word_stb | output | 1 | Mid-word strobe, one cycle |
| sync_pulse | output | 1 | One-cycle pulse on a preamble match |
| syn_flag | output | 1 | Monitor flag, inverts on each match |
| aligned | output | 1 | High once a match has set the word phase |

## Verification
`word_out`, `sync_pulse`, `syn_flag` and `aligned` all become visible one clock after the edge that accepts the deciding bit. `word_stb` becomes visible one clock after the fifth accepted bit of a word. The bench applies each bit at a falling edge and advances its reference model for the next rising edge. It then compares every output at the following falling edge, so each result is sampled in exactly the cycle it is due. Directed cases check that a word immediately after an off-phase preamble arrives intact, that an in-phase preamble changes nothing, and that a corrupted preamble in a periodic stream doubles one interval between flag changes.

// File: rtl/trs_pkg.sv
package trs_pkg;
    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } align_st_t;
endpackage

// File: rtl/trs_shift_match.sv
module trs_shift_match #(
    parameter int W = 10,
    parameter int N = 3 * W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_in,
    input  logic         bit_vld,
    output logic [W-1:0] last_word,
    output logic         hit
);
    localparam logic [N-1:0] PREAMBLE = {{(N-W){1'b0}}, {W{1'b1}}};

    logic [N-1:0] hist_q;
    logic [N-1:0] hist_nx;

    // newest bit enters at the top, so the oldest bit sits at index 0
    assign hist_nx   = {bit_in, hist_q[N-1:1]};
    assign hit       = bit_vld && (hist_nx == PREAMBLE);
    assign last_word = hist_nx[N-1 -: W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hist_q <= '0;
        else if (bit_vld)
            hist_q <= hist_nx;
    end
endmodule

// File: rtl/trs_phase_ctr.sv
module trs_phase_ctr #(
    parameter int W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic restart,
    output logic word_done,
    output logic mid_hit
);
    localparam int CW   = $clog2(W);
    localparam int HALF = W / 2;

    logic [CW-1:0] cnt_q;

    assign word_done = adv && (restart || cnt_q == CW'(W - 1));
    assign mid_hit   = adv && !restart && (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (word_done)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/trs_word_aligner.sv
module trs_word_aligner
    import trs_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_in,
    input  logic         bit_vld,
    output logic [W-1:0] word_out,
    output logic         word_stb,
    output logic         sync_pulse,
    output logic         syn_flag,
    output logic         aligned
);
    localparam int N = 3 * W;

    logic [W-1:0] last_word;
    logic         hit;
    logic         word_done;
    logic         mid_hit;
    align_st_t    state_q, state_nx;

    trs_shift_match #(.W(W), .N(N)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (bit_in),
        .bit_vld   (bit_vld),
        .last_word (last_word),
        .hit       (hit)
    );

    trs_phase_ctr #(.W(W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (bit_vld),
        .restart   (hit),
        .word_done (word_done),
        .mid_hit   (mid_hit)
    );

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_HUNT: if (hit) state_nx = ST_LOCK;
            ST_LOCK: state_nx = ST_LOCK;
            default: state_nx = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_HUNT;
        else
            state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_out   <= '0;
            word_stb   <= 1'b0;
            sync_pulse <= 1'b0;
            syn_flag   <= 1'b0;
        end else begin
            if (word_done)
                word_out <= last_word;
            word_stb   <= mid_hit;
            sync_pulse <= hit;
            if (hit)
                syn_flag <= ~syn_flag;
        end
    end

    always_comb aligned = (state_q == ST_LOCK);
endmodule

// File: rtl/trs_word_aligner_chk.sv
module trs_word_aligner_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bit_vld,
    input logic [W-1:0] word_out,
    input logic         word_stb,
    input logic         sync_pulse,
    input logic         syn_flag,
    input logic         aligned
);
    p_sync_word_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> (word_out == '0 && aligned));

    p_flag_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> (syn_flag != $past(syn_flag)));

    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_pulse |-> $stable(syn_flag));

    p_aligned_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(aligned));

    p_hunt_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !aligned |-> !syn_flag);

    p_stb_not_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_stb && sync_pulse));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> ($stable(word_out) && !word_stb && !sync_pulse));
endmodule

bind trs_word_aligner trs_word_aligner_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_vld    (bit_vld),
    .word_out   (word_out),
    .word_stb   (word_stb),
    .sync_pulse (sync_pulse),
    .syn_flag   (syn_flag),
    .aligned    (aligned)
);

// File: tb/trs_word_aligner_bench.sv
module trs_word_aligner_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bit_in = 1'b0;
    logic         bit_vld = 1'b0;
    logic [W-1:0] word_out;
    logic         word_stb, sync_pulse, syn_flag, aligned;

    trs_word_aligner #(.W(W)) u_trs_word_aligner (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .word_out(word_out), .word_stb(word_stb), .sync_pulse(sync_pulse),
        .syn_flag(syn_flag), .aligned(aligned)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    // reference model state, derived from the requirements
    logic [29:0]  m_hist;
    int           m_cnt;
    logic [W-1:0] m_word;
    logic         m_stb, m_sync, m_syn, m_al;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_hist = '0; m_cnt = 0; m_word = '0;
        m_stb = 0; m_sync = 0; m_syn = 0; m_al = 0;
    endtask

    // drive at a falling edge, model the next rising edge, compare at the next falling edge
    task automatic send_bit(input logic b, input logic v);
        logic [29:0] hn;
        logic        hit, done;
        bit_in = b;
        bit_vld = v;
        m_stb = 0;
        m_sync = 0;
        if (v) begin
            hn   = {b, m_hist[29:1]};
            hit  = (hn == 30'h3FF);
            done = hit || (m_cnt == W - 1);
            m_stb  = !hit && (m_cnt == 4);
            if (done) m_word = hn[29:20];
            m_cnt  = done ? 0 : m_cnt + 1;
            m_sync = hit;
            if (hit) begin m_syn = ~m_syn; m_al = 1; end
            m_hist = hn;
        end
        @(negedge clk);
        cyc++;
        check("R3 word_out", 32'(word_out), 32'(m_word));
        check("R6 word_stb", 32'(word_stb), 32'(m_stb));
        check("R2 sync_pulse", 32'(sync_pulse), 32'(m_sync));
        check("R7 syn_flag", 32'(syn_flag), 32'(m_syn));
        check("R8 aligned", 32'(aligned), 32'(m_al));
    endtask

    task automatic send_word(input logic [W-1:0] w);
        for (int i = 0; i < W; i++) send_bit(w[i], 1'b1);
    endtask

    task automatic send_trs();
        send_word(10'h3FF); send_word(10'h000); send_word(10'h000);
    endtask

    function automatic logic [W-1:0] safe_word(input int unsigned r);
        return W'((r & 32'h1FE) | 32'h1);
    endfunction

    task automatic do_reset();
        rst_n = 0; bit_in = 0; bit_vld = 0;
        model_reset();
        repeat (3) @(negedge clk);
        check("R1 word_out", 32'(word_out), 0);
        check("R1 flags", {28'd0, word_stb, sync_pulse, syn_flag, aligned}, 0);
        rst_n = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        logic [W-1:0] hold;
        int last_pulse, n_irreg, n_reg;
        seed = 32'd7771;
        void'($urandom(seed));
        @(negedge clk);
        do_reset();

        // R9: first word at the reset phase, then R6 mid strobe
        send_word(10'h0F3);
        check("R9 first word", 32'(word_out), 32'h0F3);
        check("R9 aligned low", 32'(aligned), 0);
        for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b1);
        check("R6 no early strobe", 32'(word_stb), 0);
        send_bit(1'b1, 1'b1);
        check("R6 strobe on fifth bit", 32'(word_stb), 1);

        // R4: off-phase preamble realigns at once
        send_bit(1'b0, 1'b1); send_bit(1'b1, 1'b1);
        send_trs();
        check("R4 sync word", 32'(word_out), 0);
        check("R2 pulse", 32'(sync_pulse), 1);
        send_word(10'h2A5);
        check("R4 word after realign", 32'(word_out), 32'h2A5);

        // R5: in-phase preamble keeps the phase
        send_word(10'h1C7);
        send_trs();
        send_word(10'h155);
        check("R5 word after in-phase match", 32'(word_out), 32'h155);

        // R10: idle cycles change nothing
        hold = word_out;
        for (int i = 0; i < 6; i++) send_bit(1'b1, 1'b0);
        check("R10 idle hold", 32'(word_out), 32'(hold));
        send_word(10'h0AB);
        check("R10 phase kept over idle", 32'(word_out), 32'h0AB);

        // random traffic with gaps and occasional preambles
        for (int k = 0; k < 400; k++) begin
            if ($urandom % 16 == 0) begin
                send_trs();
            end else begin
                send_bit(1'($urandom), ($urandom % 5) != 0);
            end
        end

        // R7: periodic preamble, one corrupted by a bit error
        last_pulse = -1; n_irreg = 0; n_reg = 0;
        for (int blk = 0; blk < 6; blk++) begin
            for (int i = 0; i < 3 * W; i++) begin
                logic b;
                b = (i < W);
                if (blk == 3 && i == 2) b = ~b;
                send_bit(b, 1'b1);
                if (sync_pulse) begin
                    if (last_pulse >= 0) begin
                        if (cyc - last_pulse == 7 * W) n_reg++;
                        else n_irreg++;
                    end
                    last_pulse = cyc;
                end
            end
            for (int j = 0; j < 4; j++) send_word(safe_word($urandom));
        end
        check("R7 irregular toggle period seen", 32'(n_irreg), 1);
        check("R7 regular periods", 32'(n_reg), 3);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule